// File: doc/BRIEF.md
# Modulo-Addressed Ring-Buffer DMA Sequencer

This block is a single-channel transfer engine for streaming audio-style data. It reads 32-bit words from a ring buffer in memory and writes each one to a fixed peripheral data register. A peripheral raises a request whenever its FIFO has room. Each request starts one burst, the minor loop, of a programmed byte count. A second counter, the major loop, counts finished bursts. At a programmed count it fires a one-cycle completion pulse, reloads itself and carries on.

The source address moves by a signed per-word offset. Only its low `m` bits may change, where `m` is the modulo setting, so the pointer stays inside a naturally aligned window of 2^m bytes. Circular playback therefore needs no reload from software. A modulo of zero turns this off, and the address then counts across the full width. The address is not adjusted when a major loop ends. Configuration is captured by a load strobe. Memory reads have a fixed latency of one cycle, and the returned word is forwarded to the peripheral port in the cycle it arrives.

Top module: `modulo_dma_seq`

## Requirements
- R1: A request that is serviced issues exactly `cfg_nbytes_i/4` memory reads (`cfg_nbytes_i` a nonzero multiple of 4), one per cycle on consecutive cycles, with no read outside such a burst.
- R2: Every read is followed one cycle later by a peripheral write that carries `rd_data_i` of that cycle. The write address is the destination latched at load, and it never advances.
- R3: `done_o` is high for exactly one cycle, together with the last write of every `cfg_nmajor_i`-th burst since load.
- R4: After each read the source address advances by the signed `cfg_soff_i`. With modulo `m` from 1 to 31, only address bits [m-1:0] change and they wrap in both directions, while bits above m-1 stay fixed.
- R5: A request that arrives while a burst is running is held and then serviced after that burst. Any further requests during the same burst merge into that single held request.
- R6: With modulo 0 the address advances by plain addition across all address bits, carrying into the upper bits.
- R7: After the completion pulse the burst counter restarts from the programmed count. Requests keep being serviced, and the source address continues from where it stopped, with no end-of-loop adjustment.
- R8: `load_i` captures all configuration and the start address, stops any running burst and discards a held request.
- R9: After reset, no read, write or completion pulse is produced until a load and a request have occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture configuration and start address |
| cfg_src_i | input | ADDR_W | Start source address |
| cfg_dst_i | input | ADDR_W | Peripheral data register address |
| cfg_soff_i | input | OFF_W | Signed source step in bytes |
| cfg_smod_i | input | SMOD_W | Source modulo bit count, 0 = off |
| cfg_nbytes_i | input | NB_W | Bytes per burst |
| cfg_nmajor_i | input | CITER_W | Bursts per completion |
| req_i | input | 1 | Peripheral transfer request |
| rd_en_o | output | 1 | Memory read strobe |
| rd_addr_o | output | ADDR_W | Memory read address |
| rd_data_i | input | DATA_W | Read data, one cycle after rd_en_o |
| wr_en_o | output | 1 | Peripheral write strobe |
| wr_addr_o | output | ADDR_W | Peripheral write address |
| wr_data_o | output | DATA_W | Peripheral write data |
| done_o | output | 1 | Major-loop completion pulse |

## Verification
Some properties hold on every cycle, and the assertions check these. The burst word counter stays in range. Upper address bits stay frozen whenever a modulo is active, and an unwrapped step is a plain add. A held request leads straight into a new burst. The completion pulse lasts one cycle and coincides with a write. The destination address does not move during writes.

Other behaviour appears only across whole scenarios, so the bench scenarios cover it. These are the exact number of writes per request and the merging of several held requests. They also include downward and upward wrap at a window edge, carry across the full width, and the cadence of completion pulses over several major loops. The bench also confirms that the pointer returns to its base after the full ring has been traversed, and that a load aborts a burst together with its held request.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int SMOD_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  soff_i,
  input  logic [SMOD_W-1:0] smod_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr_q, mask, sum, soff_ext, addr_nxt;
  logic [OFF_W-1:0]  soff_q;
  logic [SMOD_W-1:0] smod_q;

  assign soff_ext = {{(ADDR_W-OFF_W){soff_q[OFF_W-1]}}, soff_q};
  assign mask     = (smod_q == '0) ? '1 : ((ONE << smod_q) - ONE);
  assign sum      = addr_q + soff_ext;
  // upper bits frozen, low window bits wrap
  assign addr_nxt = (addr_q & ~mask) | (sum & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      soff_q <= '0;
      smod_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      soff_q <= soff_i;
      smod_q <= smod_i;
    end else if (adv_i) begin
      addr_q <= addr_nxt;
    end
  end

  assign addr_o = addr_q;

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && smod_q != '0) |=> ((addr_q & ~mask) == ($past(addr_q) & ~$past(mask)))); // R4
  AST_FULL_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && smod_q == '0) |=> (addr_q == $past(addr_q) + $past(soff_ext))); // R6
endmodule

// File: rtl/dma_loop_ctrl.sv
module dma_loop_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NB_W    = 12,
  parameter int CITER_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NB_W-1:0]    nbytes_i,
  input  logic [CITER_W-1:0] nmajor_i,
  input  logic               req_i,
  output logic               rd_en_o,
  output logic               major_end_o
);
  seq_state_e         state_q;
  logic               pend_q;
  logic [NB_W-1:0]    words_q, nwords_q, nb_words;
  logic [CITER_W-1:0] citer_q, nmajor_q;
  logic               busy, start, last;

  assign nb_words = nbytes_i >> 2;
  assign busy     = (state_q == ST_BUSY);
  assign start    = (state_q == ST_IDLE) && (pend_q || req_i) && (nwords_q != '0);
  assign last     = busy && (words_q == {{(NB_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      words_q  <= '0;
      nwords_q <= '0;
      nmajor_q <= '0;
      citer_q  <= '0;
    end else if (load_i) begin
      state_q  <= ST_IDLE;
      pend_q   <= 1'b0;
      words_q  <= '0;
      nwords_q <= nb_words;
      nmajor_q <= nmajor_i;
      citer_q  <= nmajor_i;
    end else begin
      if (start) begin
        state_q <= ST_BUSY;
        words_q <= nwords_q;
      end else if (busy) begin
        words_q <= words_q - 1'b1;
        if (last) state_q <= ST_IDLE;
      end
      // one held request; extra ones merge into it
      if (busy && req_i) pend_q <= 1'b1;
      else if (start)    pend_q <= 1'b0;
      if (last) citer_q <= (citer_q <= 1) ? nmajor_q : citer_q - 1'b1;
    end
  end

  assign rd_en_o     = busy;
  assign major_end_o = last && (citer_q <= 1);

  AST_WORDS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (words_q != '0 && words_q <= nwords_q)); // R1
  AST_PEND_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && state_q == ST_IDLE && !load_i && nwords_q != '0) |=> (state_q == ST_BUSY)); // R5
endmodule

// File: rtl/modulo_dma_seq.sv
module modulo_dma_seq #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 16,
  parameter int NB_W    = 12,
  parameter int CITER_W = 15,
  localparam int SMOD_W = $clog2(ADDR_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  cfg_src_i,
  input  logic [ADDR_W-1:0]  cfg_dst_i,
  input  logic [OFF_W-1:0]   cfg_soff_i,
  input  logic [SMOD_W-1:0]  cfg_smod_i,
  input  logic [NB_W-1:0]    cfg_nbytes_i,
  input  logic [CITER_W-1:0] cfg_nmajor_i,
  input  logic               req_i,
  output logic               rd_en_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               done_o
);
  logic              rd_en, major_end;
  logic              wr_en_q, done_q;
  logic [ADDR_W-1:0] dst_q;

  dma_loop_ctrl #(
    .NB_W    (NB_W),
    .CITER_W (CITER_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .nbytes_i    (cfg_nbytes_i),
    .nmajor_i    (cfg_nmajor_i),
    .req_i       (req_i),
    .rd_en_o     (rd_en),
    .major_end_o (major_end)
  );

  dma_addr_gen #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SMOD_W (SMOD_W)
  ) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .base_i (cfg_src_i),
    .soff_i (cfg_soff_i),
    .smod_i (cfg_smod_i),
    .adv_i  (rd_en),
    .addr_o (rd_addr_o)
  );

  // write stage: data returns one cycle after the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      dst_q   <= '0;
    end else begin
      wr_en_q <= rd_en;
      done_q  <= major_end;
      if (load_i) dst_q <= cfg_dst_i;
    end
  end

  assign rd_en_o   = rd_en;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = dst_q;
  assign wr_data_o = rd_data_i;
  assign done_o    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_ON_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_en_o); // R3
  AST_DST_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o) && !$past(load_i)) |-> $stable(wr_addr_o)); // R2
endmodule

// File: tb/tb_modulo_dma_seq.sv
module tb_modulo_dma_seq;
  localparam int AW = 32, DW = 32, OW = 16, NBW = 12, CW = 15, SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0, req = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [OW-1:0] cfg_soff = '0;
  logic [SW-1:0] cfg_smod = '0;
  logic [NBW-1:0] cfg_nbytes = '0;
  logic [CW-1:0] cfg_nmajor = '0;
  logic          rd_en, wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = '0, wr_data;

  always #2 clk = ~clk;

  modulo_dma_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_soff_i(cfg_soff),
    .cfg_smod_i(cfg_smod), .cfg_nbytes_i(cfg_nbytes), .cfg_nmajor_i(cfg_nmajor),
    .req_i(req), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (a * 32'd7) ^ 32'hC3A5_0F1E;
  endfunction

  // memory model, one-cycle latency
  always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

  int checks = 0, fails = 0;
  int nw = 0, nmaj = 0, wr_cnt = 0, done_cnt = 0, run = 0, cyc = 0;
  bit mon_en = 1'b0;
  logic [AW-1:0] exp_addr = '0, exp_dst = '0;
  logic [OW-1:0] m_soff = '0;
  logic [SW-1:0] m_smod = '0;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    logic [AW-1:0] msk, s;
    msk = (m_smod == 0) ? 32'hFFFF_FFFF : ((32'd1 << m_smod) - 32'd1);
    s   = a + {{(AW-OW){m_soff[OW-1]}}, m_soff};
    return (a & ~msk) | (s & msk);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // stream monitor
  always @(negedge clk) begin
    cyc++;
    if (mon_en && rst_n) begin
      if (wr_en) begin
        chk(wr_addr == exp_dst, "R2 wr_addr", wr_addr, exp_dst);
        chk(wr_data == pat(exp_addr), "R2/R4 wr_data", wr_data, pat(exp_addr));
        exp_addr = nxt(exp_addr);
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        chk(wr_en && (wr_cnt % (nw * nmaj) == 0), "R3 done alignment", wr_cnt, nw * nmaj);
      end
      if (rd_en) run++;
      else if (run != 0) begin
        chk(run == nw, "R1 burst length", run, nw);
        run = 0;
      end
    end
  end

  task automatic load_cfg(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [OW-1:0] o,
                          input logic [SW-1:0] m, input int nb, input int nm);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_soff = o; cfg_smod = m;
    cfg_nbytes = NBW'(nb); cfg_nmajor = CW'(nm); load = 1'b1;
    exp_addr = s; exp_dst = d; m_soff = o; m_smod = m;
    nw = nb / 4; nmaj = nm; wr_cnt = 0; done_cnt = 0; run = 0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!rd_en && !wr_en && !done, "R9 reset outputs", {rd_en, wr_en, done}, 0);
    pulse_req(); idle(5);
    chk(!rd_en && !wr_en, "R9 no transfer before load", {rd_en, wr_en}, 0);
  endtask

  task automatic t_single();
    load_cfg(32'h2000_0000, 32'h4000_0020, 16'd4, 5'd17, 64, 512);
    mon_en = 1'b1;
    pulse_req(); idle(30);
    chk(wr_cnt == 16, "R1 words per request", wr_cnt, 16);
    chk(exp_addr == 32'h2000_0040, "R4 source advance", exp_addr, 32'h2000_0040);
    chk(done_cnt == 0, "R3 no early done", done_cnt, 0);
  endtask

  task automatic t_hold();
    load_cfg(32'h2000_0000, 32'h4000_0020, 16'd4, 5'd17, 64, 512);
    pulse_req(); idle(3);
    pulse_req(); pulse_req(); pulse_req();
    idle(60);
    chk(wr_cnt == 32, "R5 held requests merge to one", wr_cnt, 32);
    chk(!rd_en, "R5 channel idle after held burst", rd_en, 0);
  endtask

  task automatic t_wrap_up();
    load_cfg(32'h1000_00F0, 32'h4000_0000, 16'd4, 5'd8, 32, 100);
    pulse_req(); idle(20); pulse_req(); idle(20);
    chk(wr_cnt == 16, "R4 up-wrap words", wr_cnt, 16);
    chk(exp_addr == 32'h1000_0030, "R4 up-wrap end address", exp_addr, 32'h1000_0030);
  endtask

  task automatic t_wrap_down();
    load_cfg(32'h1000_0008, 32'h4000_0004, 16'hFFFC, 5'd8, 16, 100);
    pulse_req(); idle(20);
    chk(wr_cnt == 4, "R4 down-wrap words", wr_cnt, 4);
    chk(exp_addr == 32'h1000_00F8, "R4 down-wrap end address", exp_addr, 32'h1000_00F8);
  endtask

  task automatic t_nowrap();
    load_cfg(32'h0000_FFF8, 32'h4000_0008, 16'd4, 5'd0, 16, 100);
    pulse_req(); idle(20);
    chk(wr_cnt == 4, "R6 words", wr_cnt, 4);
    chk(exp_addr == 32'h0001_0008, "R6 carry into upper bits", exp_addr, 32'h0001_0008);
  endtask

  task automatic t_major();
    load_cfg(32'h3000_0000, 32'h4000_0010, 16'd4, 5'd12, 16, 3);
    for (int i = 0; i < 7; i++) begin pulse_req(); idle(12); end
    chk(done_cnt == 2, "R3 done cadence", done_cnt, 2);
    chk(wr_cnt == 28, "R7 service after reload", wr_cnt, 28);
    chk(exp_addr == 32'h3000_0070, "R7 no end-of-loop adjust", exp_addr, 32'h3000_0070);
  endtask

  task automatic t_full_ring();
    load_cfg(32'h2000_0000, 32'h4000_0020, 16'd4, 5'd17, 64, 512);
    for (int i = 0; i < 2048; i++) begin pulse_req(); idle(17); end
    chk(done_cnt == 4, "R3/R7 four major loops", done_cnt, 4);
    chk(wr_cnt == 32768, "R7 total words", wr_cnt, 32768);
    chk(exp_addr == 32'h2000_0000, "R4 ring back to base", exp_addr, 32'h2000_0000);
  endtask

  task automatic t_load_abort();
    int seen;
    mon_en = 1'b0;
    load_cfg(32'h5000_0000, 32'h4000_0000, 16'd4, 5'd17, 256, 10);
    pulse_req(); idle(3);
    pulse_req();
    load_cfg(32'h6000_0100, 32'h4000_0040, 16'd4, 5'd17, 16, 10);
    idle(2);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (rd_en || wr_en) seen++; end
    chk(seen == 0, "R8 burst and held request dropped", seen, 0);
    mon_en = 1'b1;
    pulse_req(); idle(15);
    chk(wr_cnt == 4, "R8 new byte count", wr_cnt, 4);
    chk(exp_addr == 32'h6000_0110, "R8 new start address", exp_addr, 32'h6000_0110);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_hold();
    t_wrap_up();
    t_wrap_down();
    t_nowrap();
    t_major();
    t_full_ring();
    t_load_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d expected completion before 150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule